// File: doc/BRIEF.md
# Direct-Sequence Spread-Spectrum Frame Transmitter

This block turns a stream of bytes into a spread-spectrum chip stream for a baseband channel. It takes one byte at a time over a valid/ready handshake that sits directly on a synchronous FIFO's read port: `in_valid` is the inverse of the FIFO empty flag, and `in_ready` is the read request. Each accepted byte becomes one frame. The frame starts with a fixed synchronization header. After the header come two Hamming(7,4) codewords, upper nibble first. The frame is sent one bit per symbol period.

Each symbol period is one full period of a 31-chip maximal-length pseudo-noise (PN) sequence. Within a period, the frame bit is XORed with every PN chip. Each resulting chip is registered and then mapped to one of two signed 8-bit levels. Frames can follow each other with no idle chip in between. When no frame is running, the output rests at the low level. The output stream has no back-pressure and produces a chip on every clock. The upstream side holds `in_valid` and `in_data` steady until it sees `in_ready`. A byte is consumed only in a cycle in which both are high.

Top module: `dsss_tx`

## Requirements
- R1: `in_ready` is high only when `in_valid` is high and the block is either idle or on the final chip of the current frame. With `in_valid` low, `in_ready` stays low, and no byte is consumed while a frame is in progress.
- R2: A frame is the 5-bit header 5'b11110, sent from its leftmost bit (the last header bit is the 0 that marks the start of data). Then comes the codeword of the upper nibble (byte bits 7:4), then the codeword of the lower nibble. Each codeword is sent from bit 6 down to bit 0.
- R3: Nibble d3..d0 encodes to the codeword {d3, d2, d1, p2, d0, p1, p0}, listed from bit 6 to bit 0. Here p0 = d0^d1^d3, p1 = d0^d2^d3 and p2 = d1^d2^d3. For example, 4'h5 gives 7'h2d, 4'ha gives 7'h52, 4'hb gives 7'h55 and 4'h8 gives 7'h4b.
- R4: Each frame bit lasts exactly 31 chip clocks, so a frame lasts 19 × 31 = 589 chips. Chip k (0..30) of every bit uses PN element k.
- R5: The PN register is 5 bits wide and is seeded with 5'b00001. On each step it shifts toward bit 0, the new bit 4 is bit 3 XOR bit 0, and the chip is bit 0. The sequence therefore begins 1,0,0,0,0,1 and repeats every 31 chips.
- R6: The spread chip is frame bit XOR PN chip. Chip value 1 drives +63 and chip value 0 drives -64 on `chip_out`. Chip n of a frame accepted at clock edge E0 appears on `chip_out` just after edge E0+n+2.
- R7: If `in_valid` is high on the final chip of a frame, the next byte is accepted at that same edge. The next frame follows with no gap, so successive accept edges are 589 clocks apart.
- R8: After reset, and whenever no frame is running, `chip_out` is -64 and the PN register is held at its seed. A reset in the middle of a frame aborts it, and the next frame starts from the seed.
- R9: `in_data` is sampled only at the accepting edge. Changing it later does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte at the head of the source FIFO |
| in_valid | input | 1 | Source holds a byte (FIFO not empty) |
| in_ready | output | 1 | Byte accepted this cycle (FIFO read request) |
| chip_out | output | 8 | Signed channel level, +63 or -64 |

## Verification
Frames are sent for an all-zero byte, an all-ones byte, 8'h5a and two mixed bytes. The all-zero byte shows the bare PN sequence in the data bits, while the all-ones byte shows its inverse. 8'h5a pins the codeword bit order against the known codewords, and the mixed bytes separate the three parity equations and tell the nibble order apart. Further runs cover two frames sent back to back with the source held valid, a reset in the middle of a frame followed by a fresh frame, and changes to `in_data` after acceptance. These expose chip-count, PN-restart and data-capture errors.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

  localparam int NIB_W = 4;
  localparam int CW_W  = 7;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  // Hamming(7,4): {d3, d2, d1, p2, d0, p1, p0}
  function automatic logic [CW_W-1:0] ham74_encode(input logic [NIB_W-1:0] d);
    logic p0, p1, p2;
    p0 = d[0] ^ d[1] ^ d[3];
    p1 = d[0] ^ d[2] ^ d[3];
    p2 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p2, d[0], p1, p0};
  endfunction

endpackage

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen #(
  parameter int          PN_W    = 5,
  parameter logic [PN_W-1:0] PN_SEED = 5'b00001,
  parameter logic [PN_W-1:0] PN_TAPS = 5'b01001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_seed,
  output logic            pn_chip,
  output logic [PN_W-1:0] pn_state
);

  logic [PN_W-1:0] state_q;
  logic            feedback;

  assign feedback = ^(state_q & PN_TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_seed) begin
      state_q <= PN_SEED;
    end else begin
      state_q <= {feedback, state_q[PN_W-1:1]};
    end
  end

  assign pn_chip  = state_q[0];
  assign pn_state = state_q;

endmodule

// File: rtl/dsss_ham_bank.sv
module dsss_ham_bank
  import dsss_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int NIBBLES = BYTE_W / NIB_W,
  localparam int OUT_W   = NIBBLES * CW_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [OUT_W-1:0]  cw_out
);

  // Higher nibble lands in the higher codeword slot, so it is sent first.
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign cw_out[g*CW_W +: CW_W] = ham74_encode(byte_in[g*NIB_W +: NIB_W]);
  end

endmodule

// File: rtl/dsss_frame_seq.sv
module dsss_frame_seq
  import dsss_pkg::*;
#(
  parameter int FRAME_BITS = 19,
  parameter int CHIPS_PER_BIT = 31,
  localparam int BIT_W  = $clog2(FRAME_BITS),
  localparam int CHIP_W = $clog2(CHIPS_PER_BIT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [FRAME_BITS-1:0] frame_load,
  output logic                  in_ready,
  output logic                  busy,
  output logic                  cur_bit,
  output logic [CHIP_W-1:0]     chip_pos
);

  tx_state_e             state_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [BIT_W-1:0]      bit_pos_q;
  logic [CHIP_W-1:0]     chip_pos_q;
  logic                  last_chip;
  logic                  last_bit;
  logic                  frame_end;

  assign busy      = (state_q == TX_SEND);
  assign last_chip = (chip_pos_q == CHIP_W'(CHIPS_PER_BIT - 1));
  assign last_bit  = (bit_pos_q == BIT_W'(FRAME_BITS - 1));
  assign frame_end = busy && last_chip && last_bit;
  assign in_ready  = in_valid && (!busy || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      shreg_q    <= '0;
      bit_pos_q  <= '0;
      chip_pos_q <= '0;
    end else if (in_ready) begin
      state_q    <= TX_SEND;
      shreg_q    <= frame_load;
      bit_pos_q  <= '0;
      chip_pos_q <= '0;
    end else if (frame_end) begin
      state_q    <= TX_IDLE;
      bit_pos_q  <= '0;
      chip_pos_q <= '0;
    end else if (busy) begin
      if (last_chip) begin
        chip_pos_q <= '0;
        bit_pos_q  <= bit_pos_q + 1'b1;
        shreg_q    <= {shreg_q[FRAME_BITS-2:0], 1'b0};
      end else begin
        chip_pos_q <= chip_pos_q + 1'b1;
      end
    end
  end

  assign cur_bit  = shreg_q[FRAME_BITS-1];
  assign chip_pos = chip_pos_q;

endmodule

// File: rtl/dsss_spread_quant.sv
module dsss_spread_quant #(
  parameter int OUT_W  = 8,
  parameter int LVL_HI = 63,
  parameter int LVL_LO = -64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    data_bit,
  input  logic                    pn_chip,
  output logic signed [OUT_W-1:0] level
);

  localparam logic signed [OUT_W-1:0] HI = OUT_W'(LVL_HI);
  localparam logic signed [OUT_W-1:0] LO = OUT_W'(LVL_LO);

  logic spread_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spread_q <= 1'b0;
      level    <= LO;
    end else begin
      spread_q <= active & (data_bit ^ pn_chip);
      level    <= spread_q ? HI : LO;
    end
  end

endmodule

// File: rtl/dsss_tx.sv
module dsss_tx
  import dsss_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int HDR_LEN = 5,
  parameter logic [HDR_LEN-1:0] HDR_PAT = 5'b11110,
  parameter int PN_W    = 5,
  parameter logic [PN_W-1:0] PN_SEED = 5'b00001,
  parameter logic [PN_W-1:0] PN_TAPS = 5'b01001,
  parameter int OUT_W   = 8,
  parameter int LVL_HI  = 63,
  parameter int LVL_LO  = -64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic signed [OUT_W-1:0] chip_out
);

  localparam int NIBBLES    = BYTE_W / NIB_W;
  localparam int CW_BITS    = NIBBLES * CW_W;
  localparam int FRAME_BITS = HDR_LEN + CW_BITS;
  localparam int PN_LEN     = (1 << PN_W) - 1;
  localparam int CHIP_W     = $clog2(PN_LEN);

  logic [CW_BITS-1:0]  cw_bits;
  logic                busy;
  logic                cur_bit;
  logic [CHIP_W-1:0]   chip_pos;
  logic                pn_chip;
  logic [PN_W-1:0]     pn_state;

  dsss_ham_bank #(.BYTE_W(BYTE_W)) u_ham (
    .byte_in (in_data),
    .cw_out  (cw_bits)
  );

  dsss_frame_seq #(
    .FRAME_BITS    (FRAME_BITS),
    .CHIPS_PER_BIT (PN_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .frame_load ({HDR_PAT, cw_bits}),
    .in_ready   (in_ready),
    .busy       (busy),
    .cur_bit    (cur_bit),
    .chip_pos   (chip_pos)
  );

  dsss_pn_gen #(
    .PN_W    (PN_W),
    .PN_SEED (PN_SEED),
    .PN_TAPS (PN_TAPS)
  ) u_pn (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_seed (!busy),
    .pn_chip   (pn_chip),
    .pn_state  (pn_state)
  );

  dsss_spread_quant #(
    .OUT_W  (OUT_W),
    .LVL_HI (LVL_HI),
    .LVL_LO (LVL_LO)
  ) u_sq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .data_bit (cur_bit),
    .pn_chip  (pn_chip),
    .level    (chip_out)
  );

endmodule

// File: rtl/dsss_tx_chk.sv
module dsss_tx_chk #(
  parameter int FRAME_CHIPS = 589,
  parameter int PN_W    = 5,
  parameter logic [PN_W-1:0] PN_SEED = 5'b00001,
  parameter int CHIP_W  = 5,
  parameter int OUT_W   = 8,
  parameter int LVL_HI  = 63,
  parameter int LVL_LO  = -64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    busy,
  input logic [PN_W-1:0]         pn_state,
  input logic [CHIP_W-1:0]       chip_pos,
  input logic signed [OUT_W-1:0] chip_out
);

  localparam logic signed [OUT_W-1:0] HI = OUT_W'(LVL_HI);
  localparam logic signed [OUT_W-1:0] LO = OUT_W'(LVL_LO);

  int unsigned since_accept;

  always_ff @(posedge clk) begin
    if (!rst_n || in_ready) since_accept <= 0;
    else if (busy)          since_accept <= since_accept + 1;
  end

  p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  p_one_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  p_frame_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && busy) |-> (since_accept == FRAME_CHIPS - 1));

  p_pn_seed_at_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chip_pos == '0) |-> (pn_state == PN_SEED));

  p_two_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_out == HI) || (chip_out == LO));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(!busy, 2)) |-> (chip_out == LO));

endmodule

bind dsss_tx dsss_tx_chk #(
  .FRAME_CHIPS (FRAME_BITS * PN_LEN),
  .PN_W        (PN_W),
  .PN_SEED     (PN_SEED),
  .CHIP_W      (CHIP_W),
  .OUT_W       (OUT_W),
  .LVL_HI      (LVL_HI),
  .LVL_LO      (LVL_LO)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .pn_state (pn_state),
  .chip_pos (chip_pos),
  .chip_out (chip_out)
);

// File: tb/tb_dsss_tx.sv
module tb_dsss_tx;

  localparam int CLK_PERIOD  = 10;
  localparam int PN_LEN      = 31;
  localparam int FRAME_BITS  = 19;
  localparam int FRAME_CHIPS = FRAME_BITS * PN_LEN;
  localparam int LOG_N       = 16384;
  localparam logic [4:0] HDR = 5'b11110;

  // {byte, upper codeword, lower codeword}
  localparam int NVEC = 5;
  localparam logic [21:0] VEC [NVEC] = '{
    {8'h5a, 7'h2d, 7'h52},
    {8'h00, 7'h00, 7'h00},
    {8'hff, 7'h7f, 7'h7f},
    {8'hb6, 7'h55, 7'h33},
    {8'h18, 7'h07, 7'h4b}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        in_data = 8'h00;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [7:0] chip_out;

  int n_checks = 0;
  int n_fail   = 0;
  int ecount   = 0;
  int hs_n     = 0;
  int hs_log [32];
  logic signed [7:0] out_log [LOG_N];
  logic pn_ref [PN_LEN];

  dsss_tx dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .chip_out (chip_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    ecount = ecount + 1;
    if (rst_n && in_valid && in_ready && hs_n < 32) begin
      hs_log[hs_n] = ecount;
      hs_n = hs_n + 1;
    end
  end

  always @(negedge clk) begin
    if (ecount < LOG_N) out_log[ecount] = chip_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // covers R2 R3 R4 R5 R6 (and R9 when data changed after accept)
  task automatic check_frame(input int h, input logic [6:0] cwh, input logic [6:0] cwl,
                             input string req);
    logic [18:0] fw;
    int bad_n, bad_a, bad_e;
    fw = {HDR, cwh, cwl};
    bad_n = -1; bad_a = 0; bad_e = 0;
    for (int n = 0; n < FRAME_CHIPS; n++) begin
      int b, k, e;
      b = n / PN_LEN;
      k = n % PN_LEN;
      e = (fw[18-b] ^ pn_ref[k]) ? 63 : -64;
      if (bad_n < 0 && (h + n + 2) < LOG_N && int'(out_log[h+n+2]) != e) begin
        bad_n = n; bad_a = int'(out_log[h+n+2]); bad_e = e;
      end
    end
    if (bad_n >= 0) $display("  first bad chip index %0d", bad_n);
    check(bad_n < 0, req, bad_a, bad_e);
  endtask

  task automatic wait_cycles(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] q;
    int h1, h2, lo_seen;
    q = 5'b00001;
    for (int k = 0; k < PN_LEN; k++) begin
      pn_ref[k] = q[0];
      q = {q[3] ^ q[0], q[4:1]};
    end

    // reset state (R8)
    wait_cycles(4);
    check(chip_out == -8'sd64, "R8 reset level", int'(chip_out), -64);
    check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;

    // idle with empty source (R1, R8)
    lo_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (chip_out != -8'sd64 || in_ready) lo_seen++;
    end
    check(lo_seen == 0, "R1 R8 idle with empty source", lo_seen, 0);

    // table of single frames; data scrambled after accept (R9)
    for (int v = 0; v < NVEC; v++) begin
      int h0;
      h0 = hs_n;
      @(negedge clk);
      in_data  = VEC[v][21:14];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~VEC[v][21:14];
      wait_cycles(FRAME_CHIPS + 6);
      check(hs_n == h0 + 1, "R1 one accept per byte", hs_n - h0, 1);
      if (hs_n == h0 + 1)
        check_frame(hs_log[h0], VEC[v][13:7], VEC[v][6:0], "R2 R3 R4 R5 R6 R9 frame");
    end

    // back-to-back frames (R7, R1)
    begin
      int h0;
      h0 = hs_n;
      @(negedge clk);
      in_data  = 8'h5a;
      in_valid = 1'b1;
      @(negedge clk);
      in_data  = 8'hb6;
      wait_cycles(100);
      check(in_ready == 1'b0, "R1 no accept mid frame", int'(in_ready), 0);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h00;
      wait_cycles(FRAME_CHIPS + 6);
      check(hs_n == h0 + 2, "R7 two accepts", hs_n - h0, 2);
      if (hs_n == h0 + 2) begin
        h1 = hs_log[h0];
        h2 = hs_log[h0 + 1];
        check(h2 - h1 == FRAME_CHIPS, "R7 frame spacing", h2 - h1, FRAME_CHIPS);
        check_frame(h1, 7'h2d, 7'h52, "R7 first frame");
        check_frame(h2, 7'h55, 7'h33, "R7 second frame");
      end
    end

    // reset in mid-frame, then a fresh frame (R8)
    @(negedge clk);
    in_data  = 8'hff;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_cycles(200);
    rst_n = 1'b0;
    wait_cycles(3);
    check(chip_out == -8'sd64, "R8 level after mid-frame reset", int'(chip_out), -64);
    rst_n = 1'b1;
    wait_cycles(5);
    check(chip_out == -8'sd64, "R8 idle after reset release", int'(chip_out), -64);
    begin
      int h0;
      h0 = hs_n;
      @(negedge clk);
      in_data  = 8'h18;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      wait_cycles(FRAME_CHIPS + 6);
      check(hs_n == h0 + 1, "R8 accept after reset", hs_n - h0, 1);
      if (hs_n == h0 + 1)
        check_frame(hs_log[h0], 7'h07, 7'h4b, "R8 frame restarts from seed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule